// File: doc/BRIEF.md
# Privilege-Aware Endianness Aligner for Load/Store Data

This block sits between a processor's load/store unit and its data memory port. For every access it decides whether the data is handled in big-endian or little-endian byte order. The decision depends on the access kind, the effective privilege level of the access, and three status bits, one for each privilege level. Store data leaving the core and load data coming back from memory are then byte-reversed within the access width when big-endian order applies.

The access attributes (kind, privilege, size and the three status bits) are held stable by the core for as long as an access is outstanding. The store path is combinational, so converted store data leaves in the same cycle. The load path is registered: a memory response is converted using the attributes present in its cycle and appears one cycle later with a valid strobe. The chosen byte order is reported as its own output bit. Instruction fetches never use big-endian order. The read half and the write half of an atomic operation are converted in the same way. The status bits live outside this block, and their return to little-endian at reset is handled there. This block's own load register clears on reset.

Top module: `endian_aligner`

## Requirements
- R1: When acc_kind is 0 (instruction fetch), big_endian_o is 0 whatever the values of be_mach, be_sup and be_user.
- R2: For acc_kind 1 (load), 2 (store) or 3 (atomic) with acc_priv 3 (machine), big_endian_o equals be_mach.
- R3: For a data access with acc_priv 1 (supervisor), big_endian_o equals be_sup.
- R4: For a data access with acc_priv 0 (user), big_endian_o equals be_user.
- R5: For the reserved acc_priv code 2, big_endian_o is 0.
- R6: For acc_size 0 (1 byte), byte 0 of the converted data equals byte 0 of the input in either byte order, and all higher bytes are 0.
- R7: For acc_size 1, 2 or 3 (2, 4 or 8 bytes, W = 2^acc_size), output byte i (i < W) is input byte W-1-i when big_endian_o is 1 and input byte i when it is 0; bytes at index W and above are 0.
- R8: st_data_o is the R6/R7 conversion of st_data_i under the current big_endian_o, in the same cycle.
- R9: After a cycle with rsp_valid high, ld_valid_o is high for one cycle and ld_data_o holds the R6/R7 conversion of rsp_data under the attributes of that response cycle; when rsp_valid is low, ld_valid_o falls and ld_data_o keeps its value.
- R10: An atomic access (acc_kind 3) converts both st_data_o and the loaded data with the same byte order and width.
- R11: While rst_n is low, and until two clock edges after it rises, ld_valid_o and ld_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 atomic |
| acc_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| be_mach | input | 1 | Machine-level big-endian status bit |
| be_sup | input | 1 | Supervisor-level big-endian status bit |
| be_user | input | 1 | User-level big-endian status bit |
| acc_size | input | 2 | Log2 of access width in bytes |
| st_data_i | input | 64 | Store data from the core, little-endian lanes |
| st_data_o | output | 64 | Converted store data to memory |
| big_endian_o | output | 1 | Chosen byte order, 1 for big-endian |
| rsp_valid | input | 1 | Memory load response valid |
| rsp_data | input | 64 | Memory load response data |
| ld_valid_o | output | 1 | Converted load data valid |
| ld_data_o | output | 64 | Converted load data to the core |

## Verification
A wrong privilege decode or status-bit mapping shows at once on big_endian_o and on st_data_o, in the same cycle as the attributes. A fault in the load register, such as a lost clock enable or a missing reset, shows on ld_valid_o or ld_data_o exactly one edge after a response, or as a value that changes during idle cycles. Byte order faults show as swapped or leaked bytes. Because of this, each access width is exercised with distinct byte values and a full 64-bit input.

// File: rtl/endian_pkg.sv
package endian_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_ATOMIC = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUP   = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } acc_priv_e;

  typedef struct packed {
    logic mach;
    logic sup;
    logic user;
  } be_bits_t;

endpackage

// File: rtl/endian_select.sv
module endian_select
  import endian_pkg::*;
(
  input  acc_kind_e kind_i,
  input  acc_priv_e priv_i,
  input  be_bits_t  be_i,
  output logic      big_o
);

  logic is_data;

  always_comb begin
    is_data = (kind_i != KIND_FETCH);
  end

  always_comb begin
    big_o = 1'b0;
    if (is_data) begin
      unique case (priv_i)
        PRIV_MACH: big_o = be_i.mach;
        PRIV_SUP:  big_o = be_i.sup;
        PRIV_USER: big_o = be_i.user;
        default:   big_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/byte_reverser.sv
module byte_reverser #(
  parameter int DATA_W = 64,
  localparam int LANES  = DATA_W / 8,
  localparam int SIZES  = $clog2(LANES) + 1,
  localparam int SIZE_W = (SIZES > 1) ? $clog2(SIZES) : 1,
  localparam int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              big_i,
  output logic [DATA_W-1:0] data_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0]       lane;
    logic [IDX_W-1:0] src;
    logic             live;

    always_comb begin
      lane = 8'h00;
      src  = '0;
      live = 1'b0;
      for (int s = 0; s < SIZES; s++) begin
        if ((int'(size_i) == s) && (g < (1 << s))) begin
          live = 1'b1;
          src  = big_i ? IDX_W'((1 << s) - 1 - g) : IDX_W'(g);
        end
      end
      if (live) begin
        lane = data_i[8*src +: 8];
      end
    end

    assign data_o[8*g +: 8] = lane;
  end

endmodule

// File: rtl/load_stage.sv
module load_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d,  data_q;
  logic              data_en;

  always_comb begin
    data_en = valid_i;
    valid_d = valid_i;
    data_d  = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (data_en) begin
        data_q <= data_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R9
  ld_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  // R9
  ld_valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  // R9
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(data_o));

endmodule

// File: rtl/endian_aligner.sv
module endian_aligner
  import endian_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES  = DATA_W / 8,
  localparam int SIZES  = $clog2(LANES) + 1,
  localparam int SIZE_W = (SIZES > 1) ? $clog2(SIZES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_priv,
  input  logic              be_mach,
  input  logic              be_sup,
  input  logic              be_user,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [DATA_W-1:0] st_data_i,
  output logic [DATA_W-1:0] st_data_o,
  output logic              big_endian_o,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);

  logic rst_s0, rst_s1, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  assign rst_int_n = rst_s1;

  acc_kind_e kind;
  acc_priv_e priv;
  be_bits_t  be_bits;
  logic      big;

  always_comb begin
    kind         = acc_kind_e'(acc_kind);
    priv         = acc_priv_e'(acc_priv);
    be_bits.mach = be_mach;
    be_bits.sup  = be_sup;
    be_bits.user = be_user;
  end

  endian_select i_select (
    .kind_i (kind),
    .priv_i (priv),
    .be_i   (be_bits),
    .big_o  (big)
  );

  byte_reverser #(.DATA_W(DATA_W)) i_store_rev (
    .data_i (st_data_i),
    .size_i (acc_size),
    .big_i  (big),
    .data_o (st_data_o)
  );

  logic [DATA_W-1:0] ld_conv;

  byte_reverser #(.DATA_W(DATA_W)) i_load_rev (
    .data_i (rsp_data),
    .size_i (acc_size),
    .big_i  (big),
    .data_o (ld_conv)
  );

  load_stage #(.DATA_W(DATA_W)) i_load_stage (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .valid_i (rsp_valid),
    .data_i  (ld_conv),
    .valid_o (ld_valid_o),
    .data_o  (ld_data_o)
  );

  assign big_endian_o = big;

  // R1
  fetch_le_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_kind == 2'd0) |-> !big_endian_o);

  // R2
  mach_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_kind != 2'd0 && acc_priv == 2'd3) |-> (big_endian_o == be_mach));

  // R3
  sup_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_kind != 2'd0 && acc_priv == 2'd1) |-> (big_endian_o == be_sup));

  // R4
  user_order_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_kind != 2'd0 && acc_priv == 2'd0) |-> (big_endian_o == be_user));

  // R6
  byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_size == '0) |-> (st_data_o == {{(DATA_W-8){1'b0}}, st_data_i[7:0]}));

endmodule

// File: tb/test_endian_aligner.sv
`timescale 1ns/1ps
module test_endian_aligner;

  logic        clk;
  logic        rst_n;
  logic [1:0]  acc_kind;
  logic [1:0]  acc_priv;
  logic        be_mach, be_sup, be_user;
  logic [1:0]  acc_size;
  logic [63:0] st_data_i, st_data_o;
  logic        big_endian_o;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        ld_valid_o;
  logic [63:0] ld_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  endian_aligner i_endian_aligner (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_kind     (acc_kind),
    .acc_priv     (acc_priv),
    .be_mach      (be_mach),
    .be_sup       (be_sup),
    .be_user      (be_user),
    .acc_size     (acc_size),
    .st_data_i    (st_data_i),
    .st_data_o    (st_data_o),
    .big_endian_o (big_endian_o),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .ld_valid_o   (ld_valid_o),
    .ld_data_o    (ld_data_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] conv(input logic [63:0] d, input int sz, input bit be);
    logic [63:0] r;
    int w;
    r = '0;
    w = 1 << sz;
    for (int i = 0; i < w; i++) begin
      r[i*8 +: 8] = be ? d[(w-1-i)*8 +: 8] : d[i*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_acc(input int kind, input int priv, input bit m, input bit s,
                         input bit u, input int sz);
    acc_kind = 2'(kind);
    acc_priv = 2'(priv);
    be_mach  = m;
    be_sup   = s;
    be_user  = u;
    acc_size = 2'(sz);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    rsp_valid = 1'b1;
    rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
    set_acc(1, 3, 0, 0, 0, 3);
    st_data_i = '0;
    repeat (3) @(negedge clk);
    // R11
    check("R11 valid in reset", {63'd0, ld_valid_o}, 64'd0);
    check("R11 data in reset", ld_data_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 valid during release", {63'd0, ld_valid_o}, 64'd0);
    rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fetch;
    st_data_i = 64'h0102_0304_0506_0708;
    for (int p = 0; p < 4; p++) begin
      set_acc(0, p, 1, 1, 1, 3);
      #1;
      // R1
      check("R1 fetch order", {63'd0, big_endian_o}, 64'd0);
      check("R1 fetch data", st_data_o, 64'h0102_0304_0506_0708);
    end
  endtask

  task automatic t_priv;
    st_data_i = 64'h1122_3344_5566_7788;
    set_acc(1, 3, 1, 0, 0, 3); #1;
    check("R2 machine be set", {63'd0, big_endian_o}, 64'd1);
    set_acc(2, 3, 0, 1, 1, 3); #1;
    check("R2 machine be clear", {63'd0, big_endian_o}, 64'd0);
    set_acc(1, 1, 0, 1, 0, 3); #1;
    check("R3 supervisor be set", {63'd0, big_endian_o}, 64'd1);
    set_acc(2, 1, 1, 0, 1, 3); #1;
    check("R3 supervisor be clear", {63'd0, big_endian_o}, 64'd0);
    set_acc(1, 0, 0, 0, 1, 3); #1;
    check("R4 user be set", {63'd0, big_endian_o}, 64'd1);
    set_acc(2, 0, 1, 1, 0, 3); #1;
    check("R4 user be clear", {63'd0, big_endian_o}, 64'd0);
    set_acc(1, 2, 1, 1, 1, 3); #1;
    check("R5 reserved priv", {63'd0, big_endian_o}, 64'd0);
    check("R5 reserved data", st_data_o, st_data_i);
  endtask

  task automatic t_sizes;
    st_data_i = 64'hA1B2_C3D4_E5F6_0718;
    for (int be = 0; be < 2; be++) begin
      for (int sz = 0; sz < 4; sz++) begin
        set_acc(2, 3, be[0], 0, 0, sz);
        #1;
        if (sz == 0) begin
          // R6
          check("R6 single byte", st_data_o, 64'h18);
        end else begin
          // R7 and R8
          check("R7 R8 store width", st_data_o, conv(st_data_i, sz, be[0]));
        end
      end
    end
  endtask

  task automatic t_load;
    set_acc(1, 0, 0, 0, 1, 2);
    @(negedge clk);
    rsp_valid = 1'b1;
    rsp_data  = 64'hDEAD_BEEF_0A0B_0C0D;
    #1;
    check("R9 valid not early", {63'd0, ld_valid_o}, 64'd0);
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data  = 64'h5555_5555_5555_5555;
    set_acc(1, 0, 0, 0, 0, 3);
    #1;
    // R9
    check("R9 valid after response", {63'd0, ld_valid_o}, 64'd1);
    check("R9 load data", ld_data_o, 64'h0000_0000_0D0C_0B0A);
    @(negedge clk);
    check("R9 valid falls", {63'd0, ld_valid_o}, 64'd0);
    check("R9 data held", ld_data_o, 64'h0000_0000_0D0C_0B0A);
    set_acc(1, 3, 0, 0, 0, 1);
    rsp_valid = 1'b1;
    rsp_data  = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    rsp_valid = 1'b0;
    #1;
    check("R9 little-endian halfword", ld_data_o, 64'h0000_0000_0000_DEF0);
    @(negedge clk);
  endtask

  task automatic t_atomic;
    set_acc(3, 1, 0, 1, 0, 3);
    st_data_i = 64'h0011_2233_4455_6677;
    rsp_valid = 1'b1;
    rsp_data  = 64'h8899_AABB_CCDD_EEFF;
    #1;
    // R10
    check("R10 atomic order", {63'd0, big_endian_o}, 64'd1);
    check("R10 atomic write half", st_data_o, 64'h7766_5544_3322_1100);
    @(negedge clk);
    rsp_valid = 1'b0;
    #1;
    check("R10 atomic read half", ld_data_o, 64'hFFEE_DDCC_BBAA_9988);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_fetch();
    t_priv();
    t_sizes();
    t_load();
    t_atomic();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule